// File: doc/BRIEF.md
# UART Flow Control Engine

This block decides when a UART link may move data in each direction. On the receive side it watches how full the receive FIFO is. It drops the request-to-send line once the fill climbs to a programmed halt mark, and raises the line again only after the fill has drained to a separate, lower resume mark. The two marks together give hysteresis.

On the transmit side it compares every received character with programmed XON and XOFF codes. A matching XOFF pauses the local transmitter and a matching XON lets it run again. The pause takes effect only at a character boundary. When the receive fill crosses either mark, the block can also ask the serializer to send XOFF or XON characters to the far end. These injected characters go ahead of the next FIFO character.

A 4-bit mode code selects which of two character sets are used, separately for each direction. The FIFOs and the serializer sit outside the block. The serializer starts a new FIFO character only while `tx_enable` is high. It takes an injected character whenever `inj_valid` is high. It reports each start on `tx_start` and each finished character on `tx_char_done`.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `rts` is 1, `tx_enable` is 1, `inj_valid` is 0 and `special_evt` is 0.
- R2: While `rts` is 1, a fill of at least `cfg_halt_lvl`×8 words drives `rts` to 0 on the next clock edge.
- R3: While `rts` is 0, it stays 0 as long as the fill is above `cfg_resume_lvl`×8. Once the fill is at or below that level, `rts` returns to 1 on the next edge.
- R4: The transmit-side selector is `cfg_mode[1:0]`, with 2'b10 = set 1 (XON1/XOFF1), 2'b01 = set 2 (XON2/XOFF2), 2'b11 = both sets and 2'b00 = off. With a single set selected, a received XOFF of that set drops `tx_enable` two edges after the strobe edge, and a received XON of that set raises it again with the same delay. Other characters have no effect.
- R5: With both sets selected, a halt needs XOFF1 followed by XOFF2 as consecutive received characters. A resume needs XON1 followed by XON2. A lone XOFF1 or a lone XOFF2 does not halt.
- R6: With `cfg_mode[1:0]` = 2'b00, no received character halts the transmitter, and a halt already in force is released.
- R7: A halt that arrives while a character is in progress (between `tx_start` and `tx_char_done`) keeps `tx_enable` high until the edge at which `tx_char_done` is sampled.
- R8: Every matched flow-control character (the second character in both-set mode) raises `special_evt` for one cycle, one edge after the strobe.
- R9: The receive-side selector is `cfg_mode[3:2]`, using the same encoding as R4. When `rts` falls, the block queues XOFF of the selected set; when `rts` rises, it queues XON. In both-set mode it sends the set 1 character and then the set 2 character. With 2'b00 nothing is queued.
- R10: While an injected character is queued, `tx_enable` is 0. `inj_valid` is never 1 while a character is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 4 | [3:2] receive-side set, [1:0] transmit-side set |
| cfg_halt_lvl | input | 4 | Halt mark, in units of 8 words |
| cfg_resume_lvl | input | 4 | Resume mark, in units of 8 words |
| cfg_xon1 | input | 8 | XON code, set 1 |
| cfg_xon2 | input | 8 | XON code, set 2 |
| cfg_xoff1 | input | 8 | XOFF code, set 1 |
| cfg_xoff2 | input | 8 | XOFF code, set 2 |
| rx_fill | input | 8 | Receive FIFO word count |
| rx_strobe | input | 1 | A character was received this cycle |
| rx_char | input | 8 | Received character |
| tx_start | input | 1 | Serializer began a character |
| tx_char_done | input | 1 | Serializer finished a character |
| rts | output | 1 | 1 = far end may send |
| tx_enable | output | 1 | Serializer may start a FIFO character |
| inj_valid | output | 1 | An injected character is offered |
| inj_char | output | 8 | Injected character code |
| special_evt | output | 1 | One-cycle pulse on a flow-control character match |

## Verification
The assertions check four properties on every cycle:
- each `rts` edge is justified by the fill measured against the mark in force;
- `special_evt` only ever follows a received character;
- a queued injection always holds `tx_enable` low;
- no injection is offered during a character.

Only the bench scenarios can show the rest:
- the hysteresis band itself;
- the two-character sequence needed in both-set mode;
- the release of a halt when matching is switched off;
- the ordering of the two injected characters.

The bench also shows that a halt is deferred to the end of the character in progress.

// File: rtl/flowctl_pkg.sv
// Shared definitions for the UART flow control engine.
// Assumes the 2-bit set selector encoding used on both halves of the mode code.
package flowctl_pkg;
    typedef enum logic [1:0] {
        SET_NONE = 2'b00,
        SET_TWO  = 2'b01,
        SET_ONE  = 2'b10,
        SET_BOTH = 2'b11
    } charset_e;
endpackage

// File: rtl/flowctl_rts_hyst.sv
// Receive-side watermark tracker: drives rts with hysteresis between a halt
// mark and a resume mark, both given in units of (1 << SCALE_SH) words.
// Assumes fill is a registered count from the receive FIFO.
module flowctl_rts_hyst #(
    parameter int FILL_W   = 8,
    parameter int LVL_W    = 4,
    parameter int SCALE_SH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    input  logic [LVL_W-1:0]  halt_lvl,
    input  logic [LVL_W-1:0]  resume_lvl,
    output logic              rts,
    output logic              halt_evt,
    output logic              resume_evt
);
    logic [FILL_W-1:0] halt_thr;
    logic [FILL_W-1:0] resume_thr;

    // Scale the 4-bit marks to word counts.
    always_comb begin
        halt_thr   = FILL_W'(halt_lvl) << SCALE_SH;
        resume_thr = FILL_W'(resume_lvl) << SCALE_SH;
    end

    // Hysteresis state and one-cycle transition pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts        <= 1'b1;
            halt_evt   <= 1'b0;
            resume_evt <= 1'b0;
        end else begin
            halt_evt   <= 1'b0;
            resume_evt <= 1'b0;
            if (rts && fill >= halt_thr) begin
                rts      <= 1'b0;
                halt_evt <= 1'b1;
            end else if (!rts && fill <= resume_thr) begin
                rts        <= 1'b1;
                resume_evt <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/flowctl_xmatch.sv
// Transmit-side character matcher: compares received characters with the
// XON/XOFF codes of the selected set(s) and keeps the requested halt state.
// In both-set mode a match needs set 1 followed directly by set 2.
module flowctl_xmatch
    import flowctl_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  charset_e          sel,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic              strobe,
    input  logic [CHAR_W-1:0] ch,
    output logic              halt_want,
    output logic              special_evt
);
    logic prev_xoff1;
    logic prev_xon1;
    logic hit_off;
    logic hit_on;

    // Decode a match for the current character under the selected set.
    always_comb begin
        hit_off = 1'b0;
        hit_on  = 1'b0;
        if (strobe) begin
            case (sel)
                SET_ONE: begin
                    hit_off = (ch == xoff1);
                    hit_on  = (ch == xon1);
                end
                SET_TWO: begin
                    hit_off = (ch == xoff2);
                    hit_on  = (ch == xon2);
                end
                SET_BOTH: begin
                    hit_off = prev_xoff1 && (ch == xoff2);
                    hit_on  = prev_xon1 && (ch == xon2);
                end
                default: ;
            endcase
        end
    end

    // Remember whether the previous character opened a two-character pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_xoff1 <= 1'b0;
            prev_xon1  <= 1'b0;
        end else if (strobe) begin
            prev_xoff1 <= (ch == xoff1);
            prev_xon1  <= (ch == xon1);
        end
    end

    // Requested halt state and the match event pulse; XOFF wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_want   <= 1'b0;
            special_evt <= 1'b0;
        end else begin
            special_evt <= hit_off || hit_on;
            if (sel == SET_NONE)
                halt_want <= 1'b0;
            else if (hit_off)
                halt_want <= 1'b1;
            else if (hit_on)
                halt_want <= 1'b0;
        end
    end
endmodule

// File: rtl/flowctl_tx_gate.sv
// Transmit gate: applies the requested halt only at character boundaries
// and queues injected XON/XOFF characters on watermark transitions.
// Assumes the serializer pulses tx_start when it begins a character and
// tx_char_done when it ends one, and takes the injected character first.
module flowctl_tx_gate
    import flowctl_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  charset_e          sel_rx,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic              halt_evt,
    input  logic              resume_evt,
    input  logic              halt_want,
    input  logic              tx_start,
    input  logic              tx_char_done,
    output logic              tx_enable,
    output logic              inj_valid,
    output logic [CHAR_W-1:0] inj_char
);
    logic in_progress;
    logic halted;
    logic inj_pending;
    logic inj_is_off;
    logic inj_second;
    logic use_set2;

    // Track whether a character is on the line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_progress <= 1'b0;
        else if (tx_start)
            in_progress <= 1'b1;
        else if (tx_char_done)
            in_progress <= 1'b0;
    end

    // Adopt the requested halt state only between characters.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (!in_progress || tx_char_done)
            halted <= halt_want;
    end

    // Injection queue: the latest watermark transition wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_pending <= 1'b0;
            inj_is_off  <= 1'b0;
            inj_second  <= 1'b0;
        end else if ((halt_evt || resume_evt) && sel_rx != SET_NONE) begin
            inj_pending <= 1'b1;
            inj_is_off  <= halt_evt;
            inj_second  <= 1'b0;
        end else if (tx_start && inj_valid) begin
            if (sel_rx == SET_BOTH && !inj_second)
                inj_second <= 1'b1;
            else
                inj_pending <= 1'b0;
        end
    end

    // Outputs toward the serializer.
    always_comb begin
        use_set2  = (sel_rx == SET_TWO) || inj_second;
        inj_valid = inj_pending && !in_progress;
        tx_enable = !halted && !inj_pending;
        if (inj_is_off)
            inj_char = use_set2 ? xoff2 : xoff1;
        else
            inj_char = use_set2 ? xon2 : xon1;
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
// UART flow control engine top: hardware rts watermarks with hysteresis,
// XON/XOFF matching for the local transmitter and XON/XOFF injection.
// Assumes a FIFO of FIFO_DEPTH words and marks scaled by LVL_SCALE words.
module uart_flow_ctrl
    import flowctl_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int LVL_W      = 4,
    parameter int LVL_SCALE  = 8,
    parameter int CHAR_W     = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [3:0]                        cfg_mode,
    input  logic [LVL_W-1:0]                  cfg_halt_lvl,
    input  logic [LVL_W-1:0]                  cfg_resume_lvl,
    input  logic [CHAR_W-1:0]                 cfg_xon1,
    input  logic [CHAR_W-1:0]                 cfg_xon2,
    input  logic [CHAR_W-1:0]                 cfg_xoff1,
    input  logic [CHAR_W-1:0]                 cfg_xoff2,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]   rx_fill,
    input  logic                              rx_strobe,
    input  logic [CHAR_W-1:0]                 rx_char,
    input  logic                              tx_start,
    input  logic                              tx_char_done,
    output logic                              rts,
    output logic                              tx_enable,
    output logic                              inj_valid,
    output logic [CHAR_W-1:0]                 inj_char,
    output logic                              special_evt
);
    localparam int FILL_W   = $clog2(FIFO_DEPTH + 1);
    localparam int SCALE_SH = $clog2(LVL_SCALE);

    charset_e sel_rx;
    charset_e sel_tx;
    logic     halt_evt;
    logic     resume_evt;
    logic     halt_want;

    // Split the mode code into its two set selectors.
    always_comb begin
        sel_rx = charset_e'(cfg_mode[3:2]);
        sel_tx = charset_e'(cfg_mode[1:0]);
    end

    flowctl_rts_hyst #(
        .FILL_W   (FILL_W),
        .LVL_W    (LVL_W),
        .SCALE_SH (SCALE_SH)
    ) u_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill       (rx_fill),
        .halt_lvl   (cfg_halt_lvl),
        .resume_lvl (cfg_resume_lvl),
        .rts        (rts),
        .halt_evt   (halt_evt),
        .resume_evt (resume_evt)
    );

    flowctl_xmatch #(
        .CHAR_W (CHAR_W)
    ) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel_tx),
        .xon1        (cfg_xon1),
        .xon2        (cfg_xon2),
        .xoff1       (cfg_xoff1),
        .xoff2       (cfg_xoff2),
        .strobe      (rx_strobe),
        .ch          (rx_char),
        .halt_want   (halt_want),
        .special_evt (special_evt)
    );

    flowctl_tx_gate #(
        .CHAR_W (CHAR_W)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_rx       (sel_rx),
        .xon1         (cfg_xon1),
        .xon2         (cfg_xon2),
        .xoff1        (cfg_xoff1),
        .xoff2        (cfg_xoff2),
        .halt_evt     (halt_evt),
        .resume_evt   (resume_evt),
        .halt_want    (halt_want),
        .tx_start     (tx_start),
        .tx_char_done (tx_char_done),
        .tx_enable    (tx_enable),
        .inj_valid    (inj_valid),
        .inj_char     (inj_char)
    );
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
// Property checker for uart_flow_ctrl, attached through bind.
// Keeps its own model of the character-in-progress window from the
// serializer handshake.
module uart_flow_ctrl_chk #(
    parameter int FILL_W   = 8,
    parameter int LVL_W    = 4,
    parameter int SCALE_SH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  cfg_halt_lvl,
    input logic [LVL_W-1:0]  cfg_resume_lvl,
    input logic [FILL_W-1:0] rx_fill,
    input logic              rx_strobe,
    input logic              tx_start,
    input logic              tx_char_done,
    input logic              rts,
    input logic              tx_enable,
    input logic              inj_valid,
    input logic              special_evt
);
    logic busy_q;
    logic seen_q;

    // Observed character window, plus a flag that is set once the first
    // edge after reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            if (tx_start)
                busy_q <= 1'b1;
            else if (tx_char_done)
                busy_q <= 1'b0;
        end
    end

    // R2: rts may only fall after the fill reached the halt mark.
    p_rts_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $fell(rts)) |->
            ($past(rx_fill) >= (FILL_W'($past(cfg_halt_lvl)) << SCALE_SH)));

    // R3: rts may only rise after the fill drained to the resume mark.
    p_rts_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $rose(rts)) |->
            ($past(rx_fill) <= (FILL_W'($past(cfg_resume_lvl)) << SCALE_SH)));

    // R8: a match pulse always follows a received character.
    p_evt_after_char_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && special_evt) |-> $past(rx_strobe));

    // R10: an offered injection holds back FIFO characters.
    p_inj_blocks_fifo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> !tx_enable);

    // R10: no injection is offered while a character is on the line.
    p_inj_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !inj_valid);
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(
    .FILL_W   (FILL_W),
    .LVL_W    (LVL_W),
    .SCALE_SH (SCALE_SH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_halt_lvl   (cfg_halt_lvl),
    .cfg_resume_lvl (cfg_resume_lvl),
    .rx_fill        (rx_fill),
    .rx_strobe      (rx_strobe),
    .tx_start       (tx_start),
    .tx_char_done   (tx_char_done),
    .rts            (rts),
    .tx_enable      (tx_enable),
    .inj_valid      (inj_valid),
    .special_evt    (special_evt)
);

// File: tb/uart_flow_ctrl_tb.sv
// Self-checking bench for uart_flow_ctrl: a watermark vector table, then
// directed scenarios for matching, deferral and injection.
module uart_flow_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_mode = 4'b0000;
    logic [3:0] cfg_halt_lvl = 4'd4;
    logic [3:0] cfg_resume_lvl = 4'd2;
    logic [7:0] cfg_xon1 = 8'h11;
    logic [7:0] cfg_xon2 = 8'h91;
    logic [7:0] cfg_xoff1 = 8'h13;
    logic [7:0] cfg_xoff2 = 8'h93;
    logic [7:0] rx_fill = 8'd0;
    logic       rx_strobe = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic       tx_start = 1'b0;
    logic       tx_char_done = 1'b0;
    logic       rts;
    logic       tx_enable;
    logic       inj_valid;
    logic [7:0] inj_char;
    logic       special_evt;

    int n_checks = 0;
    int n_bad = 0;

    // Fill level and expected rts, with halt mark 4 (32) and resume mark 2 (16).
    localparam logic [8:0] RTS_VEC [10] = '{
        {8'd0,  1'b1}, {8'd31, 1'b1}, {8'd32, 1'b0}, {8'd40, 1'b0},
        {8'd17, 1'b0}, {8'd16, 1'b1}, {8'd20, 1'b1}, {8'd31, 1'b1},
        {8'd32, 1'b0}, {8'd0,  1'b1}
    };

    uart_flow_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_mode       (cfg_mode),
        .cfg_halt_lvl   (cfg_halt_lvl),
        .cfg_resume_lvl (cfg_resume_lvl),
        .cfg_xon1       (cfg_xon1),
        .cfg_xon2       (cfg_xon2),
        .cfg_xoff1      (cfg_xoff1),
        .cfg_xoff2      (cfg_xoff2),
        .rx_fill        (rx_fill),
        .rx_strobe      (rx_strobe),
        .rx_char        (rx_char),
        .tx_start       (tx_start),
        .tx_char_done   (tx_char_done),
        .rts            (rts),
        .tx_enable      (tx_enable),
        .inj_valid      (inj_valid),
        .inj_char       (inj_char),
        .special_evt    (special_evt)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One received character, strobed for a single cycle.
    task automatic rx_byte(input logic [7:0] c);
        rx_strobe = 1'b1;
        rx_char   = c;
        tick();
        rx_strobe = 1'b0;
    endtask

    task automatic pulse_start();
        tx_start = 1'b1;
        tick();
        tx_start = 1'b0;
    endtask

    task automatic pulse_done();
        tx_char_done = 1'b1;
        tick();
        tx_char_done = 1'b0;
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 rts", 8'(rts), 8'd1);
        check("R1 tx_enable", 8'(tx_enable), 8'd1);
        check("R1 inj_valid", 8'(inj_valid), 8'd0);
        check("R1 special_evt", 8'(special_evt), 8'd0);

        // R2 / R3 watermark table, injection off
        for (int i = 0; i < 10; i++) begin
            rx_fill = RTS_VEC[i][8:1];
            tick();
            check("R2/R3 rts vs fill", 8'(rts), 8'(RTS_VEC[i][0]));
        end
        check("R9 no inject when rx set off", 8'(inj_valid), 8'd0);

        // R9 / R10 single set injection of XOFF1
        cfg_mode = 4'b1000;
        rx_fill  = 8'd32;
        tick();
        check("R2 rts fell", 8'(rts), 8'd0);
        tick();
        check("R9 inj_valid xoff", 8'(inj_valid), 8'd1);
        check("R9 inj_char xoff1", inj_char, 8'h13);
        check("R10 tx_enable held low", 8'(tx_enable), 8'd0);
        pulse_start();
        check("R10 inj done no valid", 8'(inj_valid), 8'd0);
        pulse_done();
        check("R10 fifo released", 8'(tx_enable), 8'd1);

        // R9 both-set injection of XON1 then XON2
        cfg_mode = 4'b1100;
        rx_fill  = 8'd0;
        tick();
        check("R3 rts rose", 8'(rts), 8'd1);
        tick();
        check("R9 inj_char xon1", inj_char, 8'h11);
        pulse_start();
        check("R10 no inject during char", 8'(inj_valid), 8'd0);
        pulse_done();
        check("R9 second inj valid", 8'(inj_valid), 8'd1);
        check("R9 inj_char xon2", inj_char, 8'h91);
        pulse_start();
        pulse_done();
        check("R9 queue empty", 8'(inj_valid), 8'd0);
        check("R9 tx_enable after queue", 8'(tx_enable), 8'd1);

        // R4 / R8 set 1 matching
        cfg_mode = 4'b0010;
        rx_byte(8'h13);
        check("R8 evt on xoff1", 8'(special_evt), 8'd1);
        tick();
        check("R8 evt one cycle", 8'(special_evt), 8'd0);
        check("R4 xoff1 halts", 8'(tx_enable), 8'd0);
        rx_byte(8'h11);
        tick();
        check("R4 xon1 resumes", 8'(tx_enable), 8'd1);
        rx_byte(8'h93);
        check("R4 other set no evt", 8'(special_evt), 8'd0);
        tick();
        check("R4 xoff2 ignored in set1", 8'(tx_enable), 8'd1);

        // R7 halt deferred to the end of the current character
        pulse_start();
        rx_byte(8'h13);
        tick();
        tick();
        check("R7 enable kept mid-char", 8'(tx_enable), 8'd1);
        pulse_done();
        check("R7 halt at char end", 8'(tx_enable), 8'd0);
        rx_byte(8'h11);
        tick();
        check("R7 resume", 8'(tx_enable), 8'd1);

        // R5 both sets need consecutive characters
        cfg_mode = 4'b0011;
        rx_byte(8'h93);
        tick();
        check("R5 lone xoff2", 8'(tx_enable), 8'd1);
        rx_byte(8'h13);
        check("R5 lone xoff1 no evt", 8'(special_evt), 8'd0);
        tick();
        check("R5 lone xoff1", 8'(tx_enable), 8'd1);
        rx_byte(8'h93);
        check("R8 evt on pair", 8'(special_evt), 8'd1);
        tick();
        check("R5 pair halts", 8'(tx_enable), 8'd0);

        // R6 switching matching off releases the halt
        cfg_mode = 4'b0000;
        tick();
        tick();
        check("R6 release when off", 8'(tx_enable), 8'd1);
        rx_byte(8'h13);
        check("R6 no evt when off", 8'(special_evt), 8'd0);
        tick();
        check("R6 xoff1 ignored when off", 8'(tx_enable), 8'd1);

        // R4 set 2 matching
        cfg_mode = 4'b0001;
        rx_byte(8'h93);
        tick();
        check("R4 xoff2 halts in set2", 8'(tx_enable), 8'd0);
        rx_byte(8'h91);
        tick();
        check("R4 xon2 resumes in set2", 8'(tx_enable), 8'd1);

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule